// File: doc/BRIEF.md
# Reset Control Port and Configuration Index Decoder

This block sits on a simple host I/O bus and answers two kinds of access in the legacy configuration window at ports 0xCF8 to 0xCFB. A single-byte access at exactly 0xCF9 reaches a one-byte reset control register. Any other access that starts inside the window goes to the 32-bit configuration index latch. The reset register claims its byte ahead of the index window, and this priority does not depend on how the two parts are wired together.

A byte written to the reset register with bit 2 set asks for a system reset. The block answers with a single-cycle pulse and leaves the register as it was. A byte written with bit 2 clear keeps only bit 1, the reset-type bit, and drops every other bit. Reading the port returns the stored byte. The bench drives the synchronous reset input to model the system reset that follows a request, and that reset clears the register.

Top module: `rstctl_io_decoder`

## Requirements
- R1: A write with io_size = 0 (one byte) at port 0xCF9 with io_wdata bit 2 set raises sys_rst_req for exactly the one cycle after the write strobe, and rst_type keeps its value.
- R2: A one-byte write at 0xCF9 with bit 2 clear sets rst_type to io_wdata bit 1, visible the cycle after the strobe. All other data bits are discarded, so the register only ever holds 0x00 or 0x02.
- R3: A one-byte read at 0xCF9 returns {rst_type, 1'b0} in io_rdata[7:0], with all upper bits zero, in the cycle after the read strobe.
- R4: While rst is high at a clock edge, rst_type, cfg_addr, sys_rst_req and io_rdata all become zero.
- R5: A write with io_size = 2 (four bytes) at 0xCF8 loads all 32 bits of io_wdata into cfg_addr, visible the cycle after the strobe.
- R6: A one-byte write at 0xCF9 never changes cfg_addr, even though 0xCF9 lies inside the index window.
- R7: Only a one-byte access at exactly 0xCF9 reaches the reset register. A write at 0xCF9 of size 1 (two bytes) or 2 (four bytes) neither pulses sys_rst_req nor changes rst_type. A write inside the window other than a four-byte write at 0xCF8 leaves cfg_addr unchanged.
- R8: Any other read that starts at an address A in 0xCF8..0xCFB returns cfg_addr shifted right by 8*(A-0xCF8), keeping the low 1, 2 or 4 bytes for io_size 0, 1 or 2.
- R9: An access that starts outside 0xCF8..0xCFB, or that uses the reserved io_size = 3, has no effect on any output and reads as zero.
- R10: io_rdata is zero in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| io_addr | input | 16 | Start port address of the access |
| io_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| io_wdata | input | 32 | Write data, with the lowest byte at the start address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 32 | Registered read data, valid the cycle after io_rd |
| sys_rst_req | output | 1 | Single-cycle system reset request |
| rst_type | output | 1 | Stored reset-type bit |
| cfg_addr | output | 32 | Configuration index latch |

## Verification
The bench aims at the overlap between the two parts. Byte writes at 0xCF9 must leave the index latch alone, and wider accesses at 0xCF9 must never reach the reset register. A decoder with the priority reversed would corrupt cfg_addr on every reset write, and one that only compared addresses would fire resets on word writes. It also writes values such as 0xFF and 0x06, where bit 2 and bit 1 are both set. A design that updates the register on a reset write would change rst_type there, and one that masks badly would read back values other than 0x00 and 0x02. Byte and word reads at each lane, reserved sizes and addresses just outside the window catch lane-shift errors and decoding that leaks past the window.

// File: rtl/rstio_pkg.sv
package rstio_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  // Decode result for one access
  typedef struct packed {
    logic       rcr_hit;   // byte access at the reset control port
    logic       win_hit;   // start address inside the index window
    logic       idx_load;  // full-width access at the window base
    logic [1:0] lane;      // byte offset of start address inside window
  } dec_t;

endpackage

// File: rtl/rstio_decode.sv
module rstio_decode
  import rstio_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 16'hCF8,
  parameter int RCR_OFS  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

  logic [ADDR_W-1:0] ofs;
  logic              in_win;
  logic              size_ok;

  always_comb begin
    ofs     = addr - BASE;
    in_win  = (ofs < ADDR_W'(4));
    size_ok = (io_size_e'(size) != SZ_RSVD);
    // The reset port outranks the window; no window path sees it.
    dec.rcr_hit  = in_win && (ofs[1:0] == 2'(RCR_OFS)) &&
                   (io_size_e'(size) == SZ_BYTE);
    dec.win_hit  = in_win && size_ok && !dec.rcr_hit;
    dec.idx_load = dec.win_hit && (ofs[1:0] == 2'd0) &&
                   (io_size_e'(size) == SZ_DWORD);
    dec.lane     = ofs[1:0];
  end
endmodule

// File: rtl/rstio_rcr.sv
module rstio_rcr #(
  parameter int REQ_BIT  = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  output logic       req_pulse,
  output logic       type_q,
  output logic [7:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_pulse <= 1'b0;
      type_q    <= 1'b0;
    end else begin
      req_pulse <= wr_en && wbyte[REQ_BIT];
      if (wr_en && !wbyte[REQ_BIT])
        type_q <= wbyte[TYPE_BIT];
    end
  end

  always_comb begin
    rd_byte           = '0;
    rd_byte[TYPE_BIT] = type_q;
  end
endmodule

// File: rtl/rstio_cfgidx.sv
module rstio_cfgidx
  import rstio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] idx_q,
  output logic [DATA_W-1:0] rd_val
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] mask;
  int unsigned       nbytes;

  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (load) idx_q <= wdata;
  end

  always_comb begin
    shifted = idx_q >> {lane, 3'b000};
    case (io_size_e'(size))
      SZ_BYTE:  nbytes = 1;
      SZ_WORD:  nbytes = 2;
      SZ_DWORD: nbytes = 4;
      default:  nbytes = 0;
    endcase
    for (int b = 0; b < LANES; b++)
      mask[b*8 +: 8] = (b < nbytes) ? 8'hFF : 8'h00;
    rd_val = shifted & mask;
  end
endmodule

// File: rtl/rstio_rdmux.sv
module rstio_rdmux
  import rstio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  dec_t              dec,
  input  logic [7:0]        rcr_byte,
  input  logic [DATA_W-1:0] idx_val,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    if (dec.rcr_hit)      sel = {{(DATA_W-8){1'b0}}, rcr_byte};
    else if (dec.win_hit) sel = idx_val;
    else                  sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
    else         rdata <= '0;
  end
endmodule

// File: rtl/rstctl_io_decoder.sv
module rstctl_io_decoder
  import rstio_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int WIN_BASE = 16'hCF8,
  parameter int RCR_OFS  = 1,
  parameter int REQ_BIT  = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              sys_rst_req,
  output logic              rst_type,
  output logic [DATA_W-1:0] cfg_addr
);
  dec_t              dec;
  logic [7:0]        rcr_byte;
  logic [DATA_W-1:0] idx_val;

  rstio_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .RCR_OFS(RCR_OFS)
  ) u_dec (
    .addr(io_addr), .size(io_size), .dec(dec)
  );

  rstio_rcr #(
    .REQ_BIT(REQ_BIT), .TYPE_BIT(TYPE_BIT)
  ) u_rcr (
    .clk(clk), .rst(rst),
    .wr_en(io_wr && dec.rcr_hit),
    .wbyte(io_wdata[7:0]),
    .req_pulse(sys_rst_req),
    .type_q(rst_type),
    .rd_byte(rcr_byte)
  );

  rstio_cfgidx #(
    .DATA_W(DATA_W)
  ) u_idx (
    .clk(clk), .rst(rst),
    .load(io_wr && dec.idx_load),
    .wdata(io_wdata),
    .lane(dec.lane),
    .size(io_size),
    .idx_q(cfg_addr),
    .rd_val(idx_val)
  );

  rstio_rdmux #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd(io_rd), .dec(dec),
    .rcr_byte(rcr_byte), .idx_val(idx_val), .rdata(io_rdata)
  );
endmodule

// File: rtl/rstctl_io_decoder_chk.sv
module rstctl_io_decoder_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int WIN_BASE = 16'hCF8,
  parameter int RCR_OFS  = 1,
  parameter int REQ_BIT  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic [1:0]        io_size,
  input logic [DATA_W-1:0] io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_rdata,
  input logic              sys_rst_req,
  input logic              rst_type,
  input logic [DATA_W-1:0] cfg_addr
);
  logic rcr_wr, idx_wr, rd_outside;
  assign rcr_wr = io_wr && io_size == 2'd0 &&
                  io_addr == ADDR_W'(WIN_BASE + RCR_OFS);
  assign idx_wr = io_wr && io_size == 2'd2 && io_addr == ADDR_W'(WIN_BASE);
  assign rd_outside = io_rd && (io_addr < ADDR_W'(WIN_BASE) ||
                                io_addr > ADDR_W'(WIN_BASE + 3));

  // R1
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req == $past(rcr_wr && io_wdata[REQ_BIT]));
  // R1
  req_keeps_type_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $stable(rst_type));
  // R7
  type_only_by_port_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rst_type) |-> $past(rcr_wr) || $past(rst));
  // R6
  idx_only_by_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_addr) |-> $past(idx_wr) || $past(rst));
  // R10
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(io_rd) |-> io_rdata == '0);
  // R9
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_outside) |-> io_rdata == '0);
endmodule

bind rstctl_io_decoder rstctl_io_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE),
  .RCR_OFS(RCR_OFS), .REQ_BIT(REQ_BIT)
) u_chk (.*);

// File: tb/rstctl_io_decoder_bench.sv
module rstctl_io_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [31:0] io_rdata;
  logic        sys_rst_req;
  logic        rst_type;
  logic [31:0] cfg_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic        m_type = 1'b0;
  logic [31:0] m_cfg  = '0;

  always #2 clk = ~clk;

  rstctl_io_decoder u_rstctl_io_decoder (.*);

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [15:0] a,
                                         input logic [1:0] s);
    logic [31:0] v;
    if (s == 2'd3) return 32'h0;
    if (a == 16'hCF9 && s == 2'd0) return {30'h0, m_type, 1'b0};
    if (a < 16'hCF8 || a > 16'hCFB) return 32'h0;
    v = m_cfg >> (8 * (a - 16'hCF8));
    if (s == 2'd0) v &= 32'hFF;
    else if (s == 2'd1) v &= 32'hFFFF;
    return v;
  endfunction

  task automatic do_wr(input logic [15:0] a, input logic [1:0] s,
                       input logic [31:0] d);
    logic pulse;
    @(negedge clk);
    io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    pulse = 1'b0;
    if (a == 16'hCF9 && s == 2'd0) begin
      if (d[2]) pulse = 1'b1;
      else m_type = d[1];
    end else if (a == 16'hCF8 && s == 2'd2) begin
      m_cfg = d;
    end
    chk("R1/R7 sys_rst_req", {31'h0, sys_rst_req}, {31'h0, pulse});
    chk("R2/R7 rst_type", {31'h0, rst_type}, {31'h0, m_type});
    chk("R5/R6/R9 cfg_addr", cfg_addr, m_cfg);
    chk("R10 rdata idle", io_rdata, 32'h0);
    if (pulse) begin
      @(negedge clk);
      chk("R1 pulse one cycle", {31'h0, sys_rst_req}, 32'h0);
    end
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [1:0] s);
    @(negedge clk);
    io_addr = a; io_size = s; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk("R3/R8/R9 rdata", io_rdata, exp_rd(a, s));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_type = 1'b0; m_cfg = '0;
    chk("R4 rst_type", {31'h0, rst_type}, 32'h0);
    chk("R4 cfg_addr", cfg_addr, 32'h0);
    chk("R4 sys_rst_req", {31'h0, sys_rst_req}, 32'h0);
    chk("R4 rdata", io_rdata, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0CF9;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R4 reset rst_type", {31'h0, rst_type}, 32'h0);
    chk("R4 reset cfg_addr", cfg_addr, 32'h0);
    rst = 1'b0;

    // Directed corner cases
    do_wr(16'hCF9, 2'd0, 32'hFF);          // R1: request, type unchanged
    do_wr(16'hCF9, 2'd0, 32'hFB);          // R2: keep bit1 only
    do_rd(16'hCF9, 2'd0);                  // R3: 0x02
    do_wr(16'hCF9, 2'd0, 32'h06);          // R1: type stays 1
    do_wr(16'hCF8, 2'd2, 32'h8001_2345);   // R5
    do_wr(16'hCF9, 2'd0, 32'h00);          // R6: latch untouched
    do_rd(16'hCF8, 2'd0);                  // R8 lanes
    do_rd(16'hCFA, 2'd0);
    do_rd(16'hCFB, 2'd0);
    do_rd(16'hCFA, 2'd1);
    do_rd(16'hCF8, 2'd2);
    do_rd(16'hCF9, 2'd1);                  // R7: word read goes to latch
    do_wr(16'hCF9, 2'd1, 32'h0000_0006);   // R7: no pulse
    do_wr(16'hCF9, 2'd2, 32'hFFFF_FFFF);   // R7
    do_wr(16'hCF8, 2'd0, 32'h0000_00AA);   // R7: byte at base
    do_wr(16'hCFA, 2'd1, 32'h0000_BEEF);   // R7
    do_wr(16'hCF9, 2'd3, 32'h0000_0006);   // R9 reserved size
    do_rd(16'hCF9, 2'd3);                  // R9
    do_wr(16'hCFC, 2'd2, 32'h1234_5678);   // R9
    do_rd(16'hCF7, 2'd2);                  // R9
    do_rd(16'hCFC, 2'd0);                  // R9
    do_wr(16'hCF9, 2'd0, 32'h02);
    do_reset();                            // R4 clears type
    do_rd(16'hCF9, 2'd0);

    // Constrained random traffic
    for (int i = 0; i < 800; i++) begin
      logic [15:0] a;
      logic [1:0]  s;
      logic [31:0] d;
      a = ($urandom % 4 != 0) ? 16'(16'hCF6 + ($urandom % 8))
                              : 16'($urandom);
      s = 2'($urandom % 4);
      d = $urandom;
      if ($urandom % 2 == 1) do_wr(a, s, d);
      else do_rd(a, s);
      if (i % 200 == 199) do_reset();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule